// File: doc/BRIEF.md
# Three-Valued Cube Merge Unit

This unit takes two cubes over a parameterized number of Boolean variables and merges them coordinate by coordinate, with each coordinate holding 0, 1 or don't-care. A cube pair that disagrees on one coordinate merges into a larger cube in which that coordinate becomes don't-care. A pair that disagrees on two or more coordinates yields no cube. This is the pairwise step a prime-implicant generator repeats over a whole cube list.

The same inputs also drive a containment test, which reports whether cube A is covered by cube B. A cube generator uses this test to drop redundant cubes from its list. The unit is purely combinational and holds no state. It has no clock or reset, so every output follows its inputs within the same time step.

Coordinate encoding: 2'b01 means 0, 2'b10 means 1, and 2'b11 means don't-care. The code 2'b00 is not a legal input. Coordinate i sits in bits [2i+1:2i] of every cube vector.

Top module: `cube_star_top`

## Requirements
- R1: With the encoding 01 = 0, 10 = 1, 11 = don't-care, each coordinate of a conflict-free pair merges as follows. Equal values give that value. A 0 or 1 paired with don't-care gives the 0 or 1.
- R2: `conflict_cnt` gives the number of coordinates where one input is 0 and the other is 1. The count saturates at 2.
- R3: When exactly one coordinate conflicts, `star_valid` is 1. The conflicting coordinate is 11 in `star_cube`, and every other coordinate follows the R1 rule.
- R4: When two or more coordinates conflict, `star_valid` is 0 and every bit of `star_cube` is 1.
- R5: When no coordinate conflicts, `star_valid` is 1 and `star_cube` is contained in both inputs.
- R6: `a_in_b` is 1 exactly when, in every coordinate, B equals A or B is don't-care.
- R7: The code 2'b00 never appears in any coordinate of `star_cube` when the inputs are legal.
- R8: All outputs are combinational and settle in the same time step as an input change, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cube_a | input | 2*NVARS | First cube, two bits per coordinate |
| cube_b | input | 2*NVARS | Second cube, two bits per coordinate |
| star_cube | output | 2*NVARS | Merged cube, or all ones when no cube results |
| star_valid | output | 1 | A merged cube exists (fewer than two conflicts) |
| conflict_cnt | output | 2 | Number of conflicting coordinates, saturating at 2 |
| a_in_b | output | 1 | Cube A is contained in cube B |

## Verification
The bench walks every legal pair of cubes for the default width. This covers all three conflict classes (none, exactly one, several) and every position a single conflict can take. It therefore separates a correct merge from one that misplaces the don't-care or stops counting too early.

Directed pairs cover four further cases:
- identical cubes;
- an all-don't-care cube against a specific one, in both orders, so that the containment direction is tested;
- disjoint cubes;
- an input change with no clock edge, which tests the same-step response.

// File: rtl/cube_pkg.sv
package cube_pkg;
    localparam int COORD_W = 2;
    localparam logic [COORD_W-1:0] CODE_ZERO = 2'b01;
    localparam logic [COORD_W-1:0] CODE_ONE  = 2'b10;
    localparam logic [COORD_W-1:0] CODE_DC   = 2'b11;
    localparam logic [COORD_W-1:0] CODE_NONE = 2'b00;
    localparam int CNT_W = 2;
    localparam logic [CNT_W-1:0] CNT_SAT = 2'd2;
endpackage

// File: rtl/coord_merge_cell.sv
module coord_merge_cell
    import cube_pkg::*;
(
    input  logic [COORD_W-1:0] a_code,
    input  logic [COORD_W-1:0] b_code,
    output logic [COORD_W-1:0] merged_code,
    output logic               clash,
    output logic               a_covered
);
    logic [COORD_W-1:0] overlap;

    always_comb begin
        // Intersection of the allowed-value sets; empty means 0 against 1.
        overlap     = a_code & b_code;
        clash       = (overlap == CODE_NONE);
        merged_code = clash ? CODE_DC : overlap;
        // A is covered when every value A allows is also allowed by B.
        a_covered   = ((a_code & ~b_code) == CODE_NONE);
    end
endmodule

// File: rtl/clash_counter.sv
module clash_counter
    import cube_pkg::*;
#(
    parameter int NVARS = 4
) (
    input  logic [NVARS-1:0] clash_vec,
    output logic [CNT_W-1:0] clash_cnt
);
    always_comb begin
        clash_cnt = '0;
        for (int i = 0; i < NVARS; i++) begin
            if (clash_vec[i] && clash_cnt != CNT_SAT)
                clash_cnt = clash_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cube_star_top.sv
module cube_star_top
    import cube_pkg::*;
#(
    parameter int NVARS = 4
) (
    input  logic [COORD_W*NVARS-1:0] cube_a,
    input  logic [COORD_W*NVARS-1:0] cube_b,
    output logic [COORD_W*NVARS-1:0] star_cube,
    output logic                     star_valid,
    output logic [CNT_W-1:0]         conflict_cnt,
    output logic                     a_in_b
);
    localparam int VEC_W = COORD_W * NVARS;

    logic [VEC_W-1:0] merged_vec;
    logic [NVARS-1:0] clash_vec;
    logic [NVARS-1:0] cover_vec;

    for (genvar g = 0; g < NVARS; g++) begin : g_cell
        coord_merge_cell u_cell (
            .a_code      (cube_a[g*COORD_W +: COORD_W]),
            .b_code      (cube_b[g*COORD_W +: COORD_W]),
            .merged_code (merged_vec[g*COORD_W +: COORD_W]),
            .clash       (clash_vec[g]),
            .a_covered   (cover_vec[g])
        );
    end

    clash_counter #(.NVARS(NVARS)) u_count (
        .clash_vec (clash_vec),
        .clash_cnt (conflict_cnt)
    );

    always_comb begin
        star_valid = (conflict_cnt != CNT_SAT);
        star_cube  = star_valid ? merged_vec : {VEC_W{1'b1}};
        a_in_b     = &cover_vec;
    end
endmodule

// File: rtl/cube_star_checker.sv
module cube_star_checker
    import cube_pkg::*;
#(
    parameter int NVARS = 4
) (
    input logic [COORD_W*NVARS-1:0] cube_a,
    input logic [COORD_W*NVARS-1:0] cube_b,
    input logic [COORD_W*NVARS-1:0] star_cube,
    input logic                     star_valid,
    input logic [CNT_W-1:0]         conflict_cnt,
    input logic                     a_in_b
);
    function automatic logic all_legal(input logic [COORD_W*NVARS-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NVARS; i++)
            if (v[i*COORD_W +: COORD_W] == CODE_NONE) ok = 1'b0;
        return ok;
    endfunction

    always_comb begin
        if (all_legal(cube_a) && all_legal(cube_b)) begin
            // R4: no cube means an all-ones result
            p_empty_all_dc_r4: assert (star_valid || (&star_cube));
            // R5: conflict-free merge lies inside both inputs
            p_merge_inside_r5: assert (conflict_cnt != '0 ||
                ((star_cube & ~cube_a) == '0 && (star_cube & ~cube_b) == '0 && star_valid));
            // R3: a single conflict still gives a cube
            p_single_valid_r3: assert (conflict_cnt != 2'd1 || star_valid);
            // R6: a contained A merges into A itself
            p_contained_merge_r6: assert (!a_in_b || (star_valid && star_cube == cube_a));
            // R7: no empty coordinate code is produced
            p_no_empty_code_r7: assert (all_legal(star_cube));
            // R2: count saturates
            p_count_sat_r2: assert (conflict_cnt <= CNT_SAT);
        end
    end
endmodule

bind cube_star_top cube_star_checker #(.NVARS(NVARS)) u_checker (
    .cube_a       (cube_a),
    .cube_b       (cube_b),
    .star_cube    (star_cube),
    .star_valid   (star_valid),
    .conflict_cnt (conflict_cnt),
    .a_in_b       (a_in_b)
);

// File: tb/cube_star_top_test.sv
module cube_star_top_test;
    localparam int N = 4;
    localparam int W = 2 * N;
    localparam int MAX_CYC = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] cube_a, cube_b, star_cube;
    logic star_valid, a_in_b;
    logic [1:0] conflict_cnt;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cube_star_top #(.NVARS(N)) uut (
        .cube_a(cube_a), .cube_b(cube_b), .star_cube(star_cube),
        .star_valid(star_valid), .conflict_cnt(conflict_cnt), .a_in_b(a_in_b)
    );

    // value codes: 0 -> 0, 1 -> 1, 2 -> don't-care
    function automatic logic [1:0] enc(input int v);
        return (v == 0) ? 2'b01 : (v == 1) ? 2'b10 : 2'b11;
    endfunction
    function automatic int dec(input logic [1:0] c);
        return (c == 2'b01) ? 0 : (c == 2'b10) ? 1 : 2;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h)", req, act, exp, cube_a, cube_b);
        end
    endtask

    // Behavioural reference and comparison of all outputs
    task automatic compare_all();
        int nconf = 0;
        bit cont = 1'b1;
        logic [W-1:0] exp_cube;
        string tag;
        for (int i = 0; i < N; i++) begin
            int va = dec(cube_a[2*i +: 2]);
            int vb = dec(cube_b[2*i +: 2]);
            int r;
            if (va == 2) r = vb;
            else if (vb == 2 || va == vb) r = va;
            else begin r = 2; nconf++; end
            exp_cube[2*i +: 2] = enc(r);
            if (!(vb == 2 || vb == va)) cont = 1'b0;
            if (cube_a[2*i +: 2] == 2'b00 || cube_b[2*i +: 2] == 2'b00) nconf = nconf; // never driven
        end
        if (nconf >= 2) exp_cube = '1;
        tag = (nconf == 0) ? "R1" : (nconf == 1) ? "R3" : "R4";
        chk(tag, star_cube, exp_cube);
        chk("R2", W'(conflict_cnt), W'((nconf > 2) ? 2 : nconf));
        chk((nconf == 0) ? "R5" : "R4", W'(star_valid), W'(nconf < 2));
        chk("R6", W'(a_in_b), W'(cont));
        for (int i = 0; i < N; i++)
            chk("R7", W'(star_cube[2*i +: 2] == 2'b00), W'(0));
    endtask

    function automatic logic [W-1:0] make_cube(input int idx);
        logic [W-1:0] c;
        int t = idx;
        for (int i = 0; i < N; i++) begin
            c[2*i +: 2] = enc(t % 3);
            t = t / 3;
        end
        return c;
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        cube_a = a;
        cube_b = b;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        int total = 1;
        for (int i = 0; i < N; i++) total = total * 3;
        cube_a = '1;
        cube_b = '1;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // initial state with both cubes all don't-care: R1 R6
        compare_all();
        // directed: identical, contained both ways, disjoint
        apply(make_cube(5), make_cube(5));            // R1 identical
        apply(make_cube(0), '1);                      // R6 A inside B
        apply('1, make_cube(0));                      // R6 B inside A, not contained
        apply({N{2'b01}}, {N{2'b10}});                // R4 all coordinates conflict
        apply({{(N-1){2'b11}}, 2'b01}, {{(N-1){2'b11}}, 2'b10}); // R3 lowest coordinate
        // R8: no clock edge between change and check
        @(negedge clk);
        cube_a = {N{2'b01}};
        cube_b = {{(N-1){2'b01}}, 2'b10};
        #1;
        compare_all();
        cube_b = {{(N-2){2'b01}}, 2'b10, 2'b10};
        #1;
        compare_all();
        // exhaustive sweep of legal pairs
        for (int ia = 0; ia < total; ia++)
            for (int ib = 0; ib < total; ib++)
                apply(make_cube(ia), make_cube(ib));
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < MAX_CYC) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule